// File: doc/BRIEF.md
# Congestion Packet Trimmer

This block sits on an egress path and carries IP packets as a byte stream, one byte per clock. The first byte of each packet is the first byte of its IP header. Each packet also carries a traffic class. A queue-depth input reports how full the target port currently is. When a packet carries the configured trimmable DSCP and the port is congested, the block does not drop the packet. It cuts the packet down to a header-only length. It then rewrites the DSCP to the trimmed codepoint, fixes the IP length fields (and, for IPv4, the header checksum) to match the new size, and moves the packet to a promoted traffic class. Every other packet leaves the block byte for byte as it arrived.

The length a trimmed packet keeps depends on the IP version: 64 bytes for IPv4 and 128 bytes for IPv6. A single global minimum can raise either length, so that encapsulation and transport headers survive the cut. The block holds a fixed six-byte delay line. This lets the version, DSCP and length fields be seen before the first byte leaves. The trim decision is made once per packet and then held until that packet ends.

The input must deliver each packet as one unbroken run of valid bytes from start to end. There may be idle cycles between packets, or none. Each header must describe a packet of at least 20 bytes.

Top module: `cong_trimmer`

## Requirements
- R1: A packet that is not trimmed leaves unchanged, byte for byte, with the same start and end markers. Its first byte appears exactly 6 cycles after it entered.
- R2: A packet is trimmed only when all of the following hold. Its version nibble (byte 0, bits 7:4) is 4 or 6. Its DSCP equals `cfgTrimmable`; for IPv4 the DSCP is byte 1 bits 7:2, and for IPv6 it is byte 0 bits 3:0 followed by byte 1 bits 7:6. `queueDepth` is strictly greater than `cfgThreshold`. The header length is larger than the trim length; this length is bytes 2–3 for IPv4, and for IPv6 it is bytes 4–5 plus 40.
- R3: The trim length is 64 for IPv4 and 128 for IPv6, or `cfgMinTrim` when that is larger. A trimmed packet carries exactly that many bytes, and the end marker sits on its last byte.
- R4: In a trimmed packet the DSCP bits at the positions given in R2 become `cfgTrimmedDscp`. All other bits of bytes 0 and 1, including the ECN bits, are kept.
- R5: In a trimmed packet the length field is set to the new size. For IPv4, bytes 2–3 hold the trim length. For IPv6, bytes 4–5 hold the trim length minus 40. Both fields are big-endian.
- R6: In a trimmed IPv4 packet, bytes 10–11 hold a header checksum that is valid for the rewritten header.
- R7: `outTrimmed` is high for every byte of a trimmed packet and low otherwise. `outTc` is `cfgPromoTc` for a trimmed packet and the input class for any other packet.
- R8: The congestion test uses `queueDepth` only in the cycle in which the packet's start byte enters. Changes later in the packet have no effect.
- R9: A packet whose header length equals or is below the trim length is not trimmed, even when it is congested and carries the trimmable DSCP.
- R10: A packet whose version is neither 4 nor 6 is never trimmed.
- R11: After reset, `outValid` is low until a packet has entered.
- R12: Back-to-back packets each leave as a single start…end run, in order, with nothing merged or lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inByte | input | 8 | Input packet byte |
| inValid | input | 1 | Input byte valid |
| inSop | input | 1 | Input byte is the first of its packet |
| inEop | input | 1 | Input byte is the last of its packet |
| inTc | input | 3 | Traffic class of the packet, sampled with the start byte |
| queueDepth | input | 12 | Current queue depth of the egress port |
| cfgThreshold | input | 12 | Congestion threshold on queueDepth |
| cfgTrimmable | input | 6 | DSCP that marks a packet as trimmable |
| cfgTrimmedDscp | input | 6 | DSCP written into trimmed packets |
| cfgMinTrim | input | 8 | Global minimum trim length in bytes |
| cfgPromoTc | input | 3 | Traffic class given to trimmed packets |
| outByte | output | 8 | Output packet byte |
| outValid | output | 1 | Output byte valid |
| outSop | output | 1 | Output byte is the first of its packet |
| outEop | output | 1 | Output byte is the last of its packet |
| outTc | output | 3 | Output traffic class, constant across a packet |
| outTrimmed | output | 1 | The packet being output was trimmed |

## Verification
The hardest cases are those where the decision turns on a single cycle or a single byte of length. One case is a queue depth that crosses the threshold right after the start byte. The other is a header length one byte either side of a trim length that the global minimum may or may not have raised. The bench sweeps version, DSCP match, queue depth above, equal to and below the threshold, three minimum-trim settings, and lengths of trim length minus one, equal and plus one. In every packet it flips the queue depth to the opposite side of the threshold on the cycle after the start byte. It also sends packets back to back, so that one packet's tail and the next packet's header share the delay line.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int TC_W      = 3;
  localparam int HDR_BYTES = 6;   // bytes 0..5 hold version, DSCP and both length fields
  localparam int LEN_W     = 16;

  typedef struct packed {
    logic            valid;
    logic            sop;
    logic            eop;
    logic            cong;
    logic [TC_W-1:0] tc;
    logic [7:0]      data;
  } stage_t;

  typedef struct packed {
    logic            replace;
    logic [7:0]      subByte;
    logic            forceEop;
    logic            kill;
    logic [TC_W-1:0] tc;
    logic            trimmed;
  } strobe_t;
endpackage

// File: rtl/trim_datapath.sv
module trim_datapath
  import trim_pkg::*;
#(
  parameter int DEPTH = HDR_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  stage_t                inStage,
  input  strobe_t               strobe,
  output logic [DEPTH-1:0][7:0] hdrBytes,
  output logic                  headValid,
  output logic                  headSop,
  output logic                  headCong,
  output logic [TC_W-1:0]       headTc,
  output logic [7:0]            outByte,
  output logic                  outValid,
  output logic                  outSop,
  output logic                  outEop,
  output logic [TC_W-1:0]       outTc,
  output logic                  outTrimmed
);
  stage_t sr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sr[g] <= '0;
        else     sr[g] <= inStage;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sr[g] <= '0;
        else     sr[g] <= sr[g-1];
      end
    end
    // hdrBytes[k] is header byte k when the oldest stage holds byte 0
    assign hdrBytes[g] = sr[DEPTH-1-g].data;
  end

  stage_t head;
  assign head      = sr[DEPTH-1];
  assign headValid = head.valid;
  assign headSop   = head.sop;
  assign headCong  = head.cong;
  assign headTc    = head.tc;

  assign outValid   = head.valid && !strobe.kill;
  assign outByte    = strobe.replace ? strobe.subByte : head.data;
  assign outSop     = head.sop;
  assign outEop     = head.eop || strobe.forceEop;
  assign outTc      = strobe.tc;
  assign outTrimmed = strobe.trimmed;
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import trim_pkg::*;
#(
  parameter int MIN_W   = 8,
  parameter int V4_TRIM = 64,
  parameter int V6_TRIM = 128
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [HDR_BYTES-1:0][7:0] hdrBytes,
  input  logic                      headValid,
  input  logic                      headSop,
  input  logic                      headCong,
  input  logic [TC_W-1:0]           headTc,
  input  logic [5:0]                cfgTrimmable,
  input  logic [5:0]                cfgTrimmedDscp,
  input  logic [MIN_W-1:0]          cfgMinTrim,
  input  logic [TC_W-1:0]           cfgPromoTc,
  output strobe_t                   strobe
);
  localparam logic [LEN_W-1:0] V4_LEN  = LEN_W'(V4_TRIM);
  localparam logic [LEN_W-1:0] V6_LEN  = LEN_W'(V6_TRIM);
  localparam logic [LEN_W-1:0] V6_HDR  = LEN_W'(40);

  logic [7:0] b0, b1, b2, b3, b4, b5;
  assign {b5, b4, b3, b2, b1, b0} = hdrBytes;

  // header decode, valid while the start byte is at the head of the delay line
  logic             isV4, isV6;
  logic [5:0]       dscpIn;
  logic [LEN_W:0]   lenIn;
  logic [LEN_W-1:0] baseLen, trimLen;
  logic             doTrim;
  always_comb begin
    isV4    = b0[7:4] == 4'd4;
    isV6    = b0[7:4] == 4'd6;
    dscpIn  = isV6 ? {b0[3:0], b1[7:6]} : b1[7:2];
    lenIn   = isV6 ? ({1'b0, b4, b5} + {1'b0, V6_HDR}) : {1'b0, b2, b3};
    baseLen = isV6 ? V6_LEN : V4_LEN;
    trimLen = (LEN_W'(cfgMinTrim) > baseLen) ? LEN_W'(cfgMinTrim) : baseLen;
    doTrim  = (isV4 || isV6) && (dscpIn == cfgTrimmable) && headCong &&
              (lenIn > {1'b0, trimLen});
  end

  // per-packet state, captured when the start byte leaves
  logic             trimR, v6R;
  logic [LEN_W-1:0] trimLenR, idxR, oldLenR;
  logic [7:0]       oldB1R, ckLoR;
  logic [TC_W-1:0]  tcR;

  logic             isSop;
  logic             curTrim, curV6;
  logic [LEN_W-1:0] curLen, idx, v6Len;
  logic [TC_W-1:0]  curTc;
  always_comb begin
    isSop   = headValid && headSop;
    curTrim = isSop ? doTrim  : trimR;
    curV6   = isSop ? isV6    : v6R;
    curLen  = isSop ? trimLen : trimLenR;
    curTc   = isSop ? headTc  : tcR;
    idx     = isSop ? '0      : idxR;
    v6Len   = trimLenR - V6_HDR;
  end

  // incremental IPv4 checksum: old word from bytes 10..11 now at the head
  logic [15:0] hcOld, newCk;
  logic [7:0]  newB1;
  logic [31:0] ckSum;
  logic [16:0] ckFold1, ckFold2;
  always_comb begin
    hcOld   = {hdrBytes[0], hdrBytes[1]};
    newB1   = {cfgTrimmedDscp, oldB1R[1:0]};
    ckSum   = {16'd0, ~hcOld} + {16'd0, 8'hFF, ~oldB1R} + {24'd0, newB1} +
              {16'd0, ~oldLenR} + {16'd0, trimLenR};
    ckFold1 = {1'b0, ckSum[15:0]} + {1'b0, ckSum[31:16]};
    ckFold2 = {1'b0, ckFold1[15:0]} + {16'd0, ckFold1[16]};
    newCk   = ~ckFold2[15:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trimR    <= 1'b0;
      v6R      <= 1'b0;
      trimLenR <= '0;
      idxR     <= '0;
      oldLenR  <= '0;
      oldB1R   <= '0;
      ckLoR    <= '0;
      tcR      <= '0;
    end else if (headValid) begin
      if (isSop) begin
        trimR    <= doTrim;
        v6R      <= isV6;
        trimLenR <= trimLen;
        oldLenR  <= {b2, b3};
        oldB1R   <= b1;
        tcR      <= headTc;
      end
      idxR <= (idx == '1) ? idx : idx + 1'b1;
      if (curTrim && !curV6 && idx == LEN_W'(10)) ckLoR <= newCk[7:0];
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.subByte  = hdrBytes[0];
    strobe.tc       = curTrim ? cfgPromoTc : curTc;
    strobe.trimmed  = curTrim;
    if (curTrim) begin
      strobe.forceEop = idx == curLen - 1'b1;
      strobe.kill     = idx >= curLen;
      strobe.replace  = 1'b1;
      if (!curV6) begin
        case (idx)
          LEN_W'(1):  strobe.subByte = {cfgTrimmedDscp, hdrBytes[0][1:0]};
          LEN_W'(2):  strobe.subByte = trimLenR[15:8];
          LEN_W'(3):  strobe.subByte = trimLenR[7:0];
          LEN_W'(10): strobe.subByte = newCk[15:8];
          LEN_W'(11): strobe.subByte = ckLoR;
          default:    strobe.replace = 1'b0;
        endcase
      end else begin
        case (idx)
          LEN_W'(0):  strobe.subByte = {hdrBytes[0][7:4], cfgTrimmedDscp[5:2]};
          LEN_W'(1):  strobe.subByte = {cfgTrimmedDscp[1:0], hdrBytes[0][5:0]};
          LEN_W'(4):  strobe.subByte = v6Len[15:8];
          LEN_W'(5):  strobe.subByte = v6Len[7:0];
          default:    strobe.replace = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cong_trimmer.sv
module cong_trimmer
  import trim_pkg::*;
#(
  parameter int QD_W    = 12,
  parameter int MIN_W   = 8,
  parameter int V4_TRIM = 64,
  parameter int V6_TRIM = 128
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             inByte,
  input  logic                   inValid,
  input  logic                   inSop,
  input  logic                   inEop,
  input  logic [TC_W-1:0]        inTc,
  input  logic [QD_W-1:0]        queueDepth,
  input  logic [QD_W-1:0]        cfgThreshold,
  input  logic [5:0]             cfgTrimmable,
  input  logic [5:0]             cfgTrimmedDscp,
  input  logic [MIN_W-1:0]       cfgMinTrim,
  input  logic [TC_W-1:0]        cfgPromoTc,
  output logic [7:0]             outByte,
  output logic                   outValid,
  output logic                   outSop,
  output logic                   outEop,
  output logic [TC_W-1:0]        outTc,
  output logic                   outTrimmed
);
  stage_t                    inStage;
  strobe_t                   strobe;
  logic [HDR_BYTES-1:0][7:0] hdrBytes;
  logic                      headValid, headSop, headCong;
  logic [TC_W-1:0]           headTc;

  always_comb begin
    inStage.valid = inValid;
    inStage.sop   = inSop;
    inStage.eop   = inEop;
    inStage.cong  = queueDepth > cfgThreshold;
    inStage.tc    = inTc;
    inStage.data  = inByte;
  end

  trim_datapath #(.DEPTH(HDR_BYTES)) u_dp (
    .clk, .rst, .inStage, .strobe, .hdrBytes,
    .headValid, .headSop, .headCong, .headTc,
    .outByte, .outValid, .outSop, .outEop, .outTc, .outTrimmed
  );

  trim_ctrl #(.MIN_W(MIN_W), .V4_TRIM(V4_TRIM), .V6_TRIM(V6_TRIM)) u_ctrl (
    .clk, .rst, .hdrBytes, .headValid, .headSop, .headCong, .headTc,
    .cfgTrimmable, .cfgTrimmedDscp, .cfgMinTrim, .cfgPromoTc, .strobe
  );
endmodule

// File: rtl/trim_checker.sv
module trim_checker
  import trim_pkg::*;
#(
  parameter int MIN_W   = 8,
  parameter int V6_TRIM = 128
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       inByte,
  input logic             inValid,
  input logic             inSop,
  input logic [MIN_W-1:0] cfgMinTrim,
  input logic [7:0]       outByte,
  input logic             outValid,
  input logic             outSop,
  input logic             outEop,
  input logic [TC_W-1:0]  outTc,
  input logic             outTrimmed
);
  logic [LEN_W-1:0] outCnt;
  logic             inPkt;
  logic [LEN_W-1:0] maxTrim;
  assign maxTrim = (LEN_W'(cfgMinTrim) > LEN_W'(V6_TRIM)) ? LEN_W'(cfgMinTrim) : LEN_W'(V6_TRIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      outCnt <= '0;
      inPkt  <= 1'b0;
    end else if (outValid) begin
      outCnt <= outEop ? '0 : (outSop ? LEN_W'(1) : outCnt + 1'b1);
      inPkt  <= !outEop;
    end
  end

  // R1: start byte emerges a fixed six cycles after entering
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSop) |-> ##6 (outValid && outSop));

  // R1: untrimmed bytes are the input bytes delayed six cycles
  a_r1_passthru: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outTrimmed) |-> outByte == $past(inByte, 6));

  // R7: class and trim flag do not change inside a packet
  a_r7_held: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outSop) |-> (outTrimmed == $past(outTrimmed) && outTc == $past(outTc)));

  // R3: a trimmed packet never runs past the largest possible trim length
  a_r3_bounded: assert property (@(posedge clk) disable iff (rst)
    (outValid && outTrimmed && !outSop) |-> outCnt < maxTrim);

  // R12: start only outside a packet, continuation only inside one
  a_r12_frame: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outSop ? !inPkt : inPkt));
endmodule

bind cong_trimmer trim_checker #(.MIN_W(MIN_W), .V6_TRIM(V6_TRIM)) u_chk (
  .clk, .rst, .inByte, .inValid, .inSop, .cfgMinTrim,
  .outByte, .outValid, .outSop, .outEop, .outTc, .outTrimmed
);

// File: tb/test_cong_trimmer.sv
module test_cong_trimmer;
  localparam int THR = 100;
  localparam logic [5:0] TRIMMABLE = 6'h11;
  localparam logic [5:0] TRIMMED   = 6'h2C;
  localparam logic [5:0] OTHER     = 6'h12;
  localparam logic [2:0] IN_TC     = 3'd1;
  localparam logic [2:0] PROMO_TC  = 3'd6;

  logic clk = 0, rst = 1;
  logic [7:0]  inByte = 0;
  logic        inValid = 0, inSop = 0, inEop = 0;
  logic [2:0]  inTc = 0;
  logic [11:0] queueDepth = 0;
  logic [11:0] cfgThreshold = 12'(THR);
  logic [5:0]  cfgTrimmable = TRIMMABLE, cfgTrimmedDscp = TRIMMED;
  logic [7:0]  cfgMinTrim = 0;
  logic [2:0]  cfgPromoTc = PROMO_TC;
  logic [7:0]  outByte;
  logic        outValid, outSop, outEop, outTrimmed;
  logic [2:0]  outTc;

  always #4 clk = ~clk;

  cong_trimmer i_cong_trimmer (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] pkt [0:319];
  int         pktLen;
  logic [7:0] expBuf [0:799];
  logic [7:0] gotBuf [0:799];
  int         expN, gotN, expP, gotP;
  logic [2:0] expTc [0:3];
  logic [2:0] gotTc [0:3];
  bit         expTr [0:3];
  bit         gotTr [0:3];

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (gotN < 800) gotBuf[gotN] = outByte;
      if (outSop && gotP < 4) begin gotTc[gotP] = outTc; gotTr[gotP] = outTrimmed; end
      if (outEop) gotP++;
      gotN++;
    end
  end

  function automatic logic [15:0] ckOf(input logic [159:0] h);
    int s = 0;
    for (int k = 0; k < 10; k++)
      if (k != 5) s += int'(h[159-16*k -: 16]);
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic buildPkt(input int ver, input logic [5:0] dscp, input int len, input int seed);
    logic [159:0] h;
    pktLen = len;
    for (int i = 0; i < len; i++) pkt[i] = 8'((i * 13 + seed) & 255);
    if (ver == 6) begin
      pkt[0] = {4'h6, dscp[5:2]};
      pkt[1] = {dscp[1:0], 6'h05};
      pkt[2] = 8'h12; pkt[3] = 8'h34;
      pkt[4] = 8'((len - 40) >> 8); pkt[5] = 8'((len - 40) & 255);
    end else begin
      pkt[0] = {4'(ver), 4'h5};
      pkt[1] = {dscp, 2'b01};
      pkt[2] = 8'(len >> 8); pkt[3] = 8'(len & 255);
      for (int i = 4; i < 10; i++) pkt[i] = 8'(i * 7 + 3);
      pkt[10] = 0; pkt[11] = 0;
      for (int i = 12; i < 20; i++) pkt[i] = 8'(8'hC0 + i);
      for (int i = 0; i < 20; i++) h[159-8*i -: 8] = pkt[i];
      {pkt[10], pkt[11]} = ckOf(h);
    end
  endtask

  // expected output computed from R2..R7
  task automatic appendExp(input int ver, input logic [5:0] dscp, input int qd);
    int tl, base, n;
    bit tr;
    logic [159:0] h;
    base = (ver == 6) ? 128 : 64;
    tl = (int'(cfgMinTrim) > base) ? int'(cfgMinTrim) : base;
    tr = (ver == 4 || ver == 6) && dscp == TRIMMABLE && qd > THR && pktLen > tl;
    n = tr ? tl : pktLen;
    for (int i = 0; i < n; i++) expBuf[expN + i] = pkt[i];
    if (tr && ver == 4) begin
      expBuf[expN+1] = {TRIMMED, pkt[1][1:0]};
      expBuf[expN+2] = 8'(tl >> 8); expBuf[expN+3] = 8'(tl & 255);
      expBuf[expN+10] = 0; expBuf[expN+11] = 0;
      for (int i = 0; i < 20; i++) h[159-8*i -: 8] = expBuf[expN+i];
      {expBuf[expN+10], expBuf[expN+11]} = ckOf(h);
    end else if (tr) begin
      expBuf[expN]   = {pkt[0][7:4], TRIMMED[5:2]};
      expBuf[expN+1] = {TRIMMED[1:0], pkt[1][5:0]};
      expBuf[expN+4] = 8'((tl - 40) >> 8); expBuf[expN+5] = 8'((tl - 40) & 255);
    end
    expTr[expP] = tr;
    expTc[expP] = tr ? PROMO_TC : IN_TC;
    expN += n;
    expP++;
  endtask

  // R8: queue depth flips to the other side of the threshold after the start byte
  task automatic drivePkt(input int qd);
    for (int i = 0; i < pktLen; i++) begin
      @(negedge clk);
      inValid = 1; inSop = (i == 0); inEop = (i == pktLen - 1);
      inByte = pkt[i]; inTc = IN_TC;
      queueDepth = (i == 0) ? 12'(qd) : ((qd > THR) ? 12'd0 : 12'd4000);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 0; inSop = 0; inEop = 0;
  endtask

  task automatic clearRun();
    expN = 0; gotN = 0; expP = 0; gotP = 0;
  endtask

  task automatic compareRun(input string tag);
    int bad = 0;
    repeat (12) @(negedge clk);
    check(gotN == expN, {tag, " R3 output byte count"}, gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) if (gotBuf[i] !== expBuf[i]) bad++;
    check(bad == 0, {tag, " R4 R5 R6 mismatching bytes"}, bad, 0);
    check(gotP == expP, "R12 packet count", gotP, expP);
    for (int p = 0; p < expP && p < gotP; p++) begin
      check(gotTr[p] == expTr[p], {tag, " R7 trimmed flag"}, int'(gotTr[p]), int'(expTr[p]));
      check(gotTc[p] == expTc[p], {tag, " R7 traffic class"}, int'(gotTc[p]), int'(expTc[p]));
    end
  endtask

  initial begin
    int vers [3] = '{4, 6, 5};
    int qds  [3] = '{THR + 1, THR, 0};
    int mins [3] = '{0, 100, 200};
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    check(outValid == 0, "R11 outValid after reset", int'(outValid), 0);

    for (int m = 0; m < 3; m++) begin
      cfgMinTrim = 8'(mins[m]);
      for (int v = 0; v < 3; v++)
        for (int d = 0; d < 2; d++)
          for (int q = 0; q < 3; q++)
            for (int l = 0; l < 4; l++) begin
              int base, tl, len;
              logic [5:0] dscp;
              base = (vers[v] == 6) ? 128 : 64;
              tl = (mins[m] > base) ? mins[m] : base;
              len = (l == 3) ? 300 : tl - 1 + l;  // R9 at and below, R3 above
              dscp = d ? TRIMMABLE : OTHER;
              clearRun();
              buildPkt(vers[v], dscp, len, m * 7 + l);
              appendExp(vers[v], dscp, qds[q]);
              drivePkt(qds[q]);
              idle();
              compareRun(vers[v] == 5 ? "R10" : "R2 R8");
            end
    end

    // R12: back-to-back packets, trimmed then untrimmed then trimmed
    cfgMinTrim = 0;
    clearRun();
    buildPkt(4, TRIMMABLE, 200, 3); appendExp(4, TRIMMABLE, 500); drivePkt(500);
    buildPkt(6, OTHER, 150, 5);     appendExp(6, OTHER, 500);     drivePkt(500);
    buildPkt(6, TRIMMABLE, 180, 9); appendExp(6, TRIMMABLE, 500); drivePkt(500);
    idle();
    compareRun("R12 R1");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule